// File: doc/BRIEF.md
# Triggered Event Framer with Counter Check

The framer sits on a readout motherboard between the per-channel record registers and the output word FIFO of a serial link. Each level-1 accept loads a reference bunch-crossing ID and a reference event count into a small pending queue. The framer takes the oldest pending trigger once the upstream logic shows that a full set of channel records is present. It compares the local counters in each active channel's record with the low bits of the references. It then sends one framed event into the FIFO, one 32-bit word per cycle.

A frame has a fixed start word and fixed reference words. A flag word follows, with one mismatch bit per channel, then a word that gives the active channel count. Next come two data words for each active channel, a parity word over the body of the frame, and a fixed end word. When the FIFO shows full, emission pauses and no word is lost. Records must stay stable until the framer acknowledges the frame.

Top module: `event_framer`

## Requirements
- R1: After reset the block writes nothing to the FIFO and does not acknowledge records.
- R2: A frame is, in order: 0xB0F0_0000; the reference bunch-crossing ID, zero-extended; the reference event count, zero-extended; the flag word; the active channel count; for each active channel from channel 0 upward, data bits [63:32] and then data bits [31:0]; the parity word; 0xE0F0_0000.
- R3: A channel record is 71 bits, with data in [63:0], the local bunch-crossing count in [67:64] and the local level-1 count in [70:68]. Flag word bit c is 1 only if channel c is active and its bunch-crossing count differs from reference ID bits [3:0] or its level-1 count differs from reference count bits [2:0]. All other flag word bits are 0.
- R4: The parity word is the XOR of every frame word after the start word and before the parity word.
- R5: The channel count input is sampled when a frame starts and is limited to the channel maximum (25). A count of 0 gives a 7-word frame with no data words.
- R6: While the FIFO full input is high no word is written. The frame continues afterwards with no word lost or repeated.
- R7: The references are captured on each trigger pulse into a queue of two pending entries. A trigger that arrives while two entries are pending is ignored.
- R8: The record acknowledge output is high for exactly the cycle in which the end word is written.
- R9: Queued triggers produce frames in arrival order, each carrying its own reference values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Level-1 accept pulse |
| ref_bcid_i | input | 12 | Reference bunch-crossing ID, captured with trig_i |
| ref_evcnt_i | input | 24 | Reference event count, captured with trig_i |
| rec_valid_i | input | 1 | Channel records present and stable |
| rec_i | input | 1775 | Channel records, channel c at bits [71c+70:71c] |
| n_chan_i | input | 5 | Number of active channels |
| fifo_full_i | input | 1 | Output FIFO full |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 32 | FIFO write word |
| rec_taken_o | output | 1 | Records consumed, frame complete |

## Verification
The bench aims at the flag word. It sets mismatches of only the bunch-crossing count, of only the level-1 count, and of both, on the first and last channels. A wrong bit slice or a wrong polarity would show as a misplaced or missing flag. It also sets a mismatch on an inactive channel, which a framer that ignores the active count would flag wrongly. Channel counts of 0 and of more than the maximum test the clamp and the empty-body path, where a framer that is off by one would emit stray data words. A stall pattern that changes state irregularly, together with three triggers sent close together, tests for lost or repeated words, for queue overflow and for mixed-up reference values between frames.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int DATA_W = 64;
  localparam int LBC_W  = 4;
  localparam int LL1_W  = 3;
  localparam int REC_W  = DATA_W + LBC_W + LL1_W;
  localparam int WORD_W = 32;

  localparam logic [WORD_W-1:0] SOF_WORD = 32'hB0F0_0000;
  localparam logic [WORD_W-1:0] EOF_WORD = 32'hE0F0_0000;

  typedef struct packed {
    logic [LL1_W-1:0]  l1;
    logic [LBC_W-1:0]  bc;
    logic [DATA_W-1:0] data;
  } rec_t;

  typedef enum logic [3:0] {
    S_IDLE, S_SOF, S_BCID, S_EVC, S_FLAG, S_NCH, S_DHI, S_DLO, S_PAR, S_EOF
  } frm_st_e;
endpackage

// File: rtl/trig_queue.sv
module trig_queue #(
  parameter int DEPTH  = 2,
  parameter int BCID_W = 12,
  parameter int EVC_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [BCID_W-1:0] bcid_i,
  input  logic [EVC_W-1:0]  evc_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic [BCID_W-1:0] bcid_o,
  output logic [EVC_W-1:0]  evc_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [BCID_W-1:0] bcid_q [DEPTH];
  logic [EVC_W-1:0]  evc_q  [DEPTH];
  logic [PW-1:0]     rd_ptr, wr_ptr;
  logic [CW-1:0]     count;
  logic              do_push, do_pop;

  assign do_pop  = pop_i && (count != '0);
  assign do_push = push_i && ((count != CW'(DEPTH)) || do_pop);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        bcid_q[i] <= '0;
        evc_q[i]  <= '0;
      end
    end else begin
      if (do_push) begin
        bcid_q[wr_ptr] <= bcid_i;
        evc_q[wr_ptr]  <= evc_i;
        wr_ptr         <= nxt(wr_ptr);
      end
      if (do_pop) rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign valid_o = (count != '0);
  assign bcid_o  = bcid_q[rd_ptr];
  assign evc_o   = evc_q[rd_ptr];

  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (count != '0)); // R7
  AST_FULL_IGNORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == CW'(DEPTH) && push_i && !pop_i) |=> (count == CW'(DEPTH) && $stable(wr_ptr))); // R7
endmodule

// File: rtl/cnt_check.sv
module cnt_check
  import framer_pkg::*;
#(
  parameter int N_CHAN = 25,
  parameter int CW     = $clog2(N_CHAN + 1)
) (
  input  logic [LBC_W-1:0] ref_bc_i,
  input  logic [LL1_W-1:0] ref_l1_i,
  input  logic [LBC_W-1:0] bc_i [N_CHAN],
  input  logic [LL1_W-1:0] l1_i [N_CHAN],
  input  logic [CW-1:0]    n_act_i,
  output logic [N_CHAN-1:0] flags_o
);
  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    logic active, mism;
    assign active     = (CW'(c) < n_act_i);
    assign mism       = (bc_i[c] != ref_bc_i) || (l1_i[c] != ref_l1_i);
    assign flags_o[c] = active && mism;
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import framer_pkg::*;
#(
  parameter int N_CHAN = 25,
  parameter int BCID_W = 12,
  parameter int EVC_W  = 24,
  parameter int CW     = $clog2(N_CHAN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              q_valid_i,
  input  logic [BCID_W-1:0] q_bcid_i,
  input  logic [EVC_W-1:0]  q_evc_i,
  output logic              q_pop_o,
  input  logic              rec_valid_i,
  input  logic [DATA_W-1:0] data_i [N_CHAN],
  input  logic [N_CHAN-1:0] flags_i,
  input  logic [CW-1:0]     n_act_i,
  input  logic              fifo_full_i,
  output logic              fifo_wr_o,
  output logic [WORD_W-1:0] fifo_data_o,
  output logic              rec_taken_o
);
  frm_st_e            state;
  logic [CW-1:0]      ch, n_act;
  logic [BCID_W-1:0]  bcid_q;
  logic [EVC_W-1:0]   evc_q;
  logic [N_CHAN-1:0]  flags_q;
  logic [WORD_W-1:0]  par, word;
  logic               start, in_body, last_ch;

  assign start     = (state == S_IDLE) && q_valid_i && rec_valid_i;
  assign q_pop_o   = start;
  assign fifo_wr_o = (state != S_IDLE) && !fifo_full_i;
  assign rec_taken_o = (state == S_EOF) && fifo_wr_o;
  assign in_body   = state inside {S_BCID, S_EVC, S_FLAG, S_NCH, S_DHI, S_DLO};
  assign last_ch   = ((ch + CW'(1)) == n_act);

  always_comb begin
    case (state)
      S_SOF:   word = SOF_WORD;
      S_BCID:  word = WORD_W'(bcid_q);
      S_EVC:   word = WORD_W'(evc_q);
      S_FLAG:  word = WORD_W'(flags_q);
      S_NCH:   word = WORD_W'(n_act);
      S_DHI:   word = data_i[ch][DATA_W-1:WORD_W];
      S_DLO:   word = data_i[ch][WORD_W-1:0];
      S_PAR:   word = par;
      S_EOF:   word = EOF_WORD;
      default: word = '0;
    endcase
  end
  assign fifo_data_o = word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= S_IDLE;
      ch      <= '0;
      n_act   <= '0;
      bcid_q  <= '0;
      evc_q   <= '0;
      flags_q <= '0;
      par     <= '0;
    end else if (start) begin
      state   <= S_SOF;
      ch      <= '0;
      n_act   <= n_act_i;
      bcid_q  <= q_bcid_i;
      evc_q   <= q_evc_i;
      flags_q <= flags_i;
      par     <= '0;
    end else if (fifo_wr_o) begin
      if (in_body) par <= par ^ word;
      case (state)
        S_SOF:  state <= S_BCID;
        S_BCID: state <= S_EVC;
        S_EVC:  state <= S_FLAG;
        S_FLAG: state <= S_NCH;
        S_NCH:  state <= (n_act == '0) ? S_PAR : S_DHI;
        S_DHI:  state <= S_DLO;
        S_DLO: begin
          if (last_ch) state <= S_PAR;
          else begin
            state <= S_DHI;
            ch    <= ch + CW'(1);
          end
        end
        S_PAR:  state <= S_EOF;
        S_EOF:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != S_IDLE && fifo_full_i) |=> ($stable(state) && $stable(ch) && $stable(par))); // R6
  AST_PAR_BEFORE_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_EOF && $past(state) != S_EOF) |-> ($past(state) == S_PAR)); // R4
  AST_TAKEN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_taken_o |=> !rec_taken_o); // R8
  AST_CH_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state inside {S_DHI, S_DLO}) |-> (ch < n_act)); // R5
  AST_START_FROM_QUEUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_SOF && $past(state) == S_IDLE) |-> $past(q_valid_i && rec_valid_i)); // R7
endmodule

// File: rtl/event_framer.sv
module event_framer
  import framer_pkg::*;
#(
  parameter int N_CHAN  = 25,
  parameter int BCID_W  = 12,
  parameter int EVC_W   = 24,
  parameter int Q_DEPTH = 2,
  localparam int CW     = $clog2(N_CHAN + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    trig_i,
  input  logic [BCID_W-1:0]       ref_bcid_i,
  input  logic [EVC_W-1:0]        ref_evcnt_i,
  input  logic                    rec_valid_i,
  input  logic [N_CHAN*REC_W-1:0] rec_i,
  input  logic [CW-1:0]           n_chan_i,
  input  logic                    fifo_full_i,
  output logic                    fifo_wr_o,
  output logic [WORD_W-1:0]       fifo_data_o,
  output logic                    rec_taken_o
);
  logic [DATA_W-1:0] data [N_CHAN];
  logic [LBC_W-1:0]  bc   [N_CHAN];
  logic [LL1_W-1:0]  l1   [N_CHAN];

  for (genvar c = 0; c < N_CHAN; c++) begin : g_unpack
    rec_t r;
    assign r       = rec_i[c*REC_W +: REC_W];
    assign data[c] = r.data;
    assign bc[c]   = r.bc;
    assign l1[c]   = r.l1;
  end

  logic [CW-1:0]     n_clamp;
  assign n_clamp = (n_chan_i > CW'(N_CHAN)) ? CW'(N_CHAN) : n_chan_i;

  logic              q_valid, q_pop;
  logic [BCID_W-1:0] q_bcid;
  logic [EVC_W-1:0]  q_evc;
  logic [N_CHAN-1:0] flags;

  trig_queue #(.DEPTH(Q_DEPTH), .BCID_W(BCID_W), .EVC_W(EVC_W)) i_queue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (trig_i),
    .bcid_i  (ref_bcid_i),
    .evc_i   (ref_evcnt_i),
    .pop_i   (q_pop),
    .valid_o (q_valid),
    .bcid_o  (q_bcid),
    .evc_o   (q_evc)
  );

  cnt_check #(.N_CHAN(N_CHAN), .CW(CW)) i_check (
    .ref_bc_i (q_bcid[LBC_W-1:0]),
    .ref_l1_i (q_evc[LL1_W-1:0]),
    .bc_i     (bc),
    .l1_i     (l1),
    .n_act_i  (n_clamp),
    .flags_o  (flags)
  );

  frame_seq #(.N_CHAN(N_CHAN), .BCID_W(BCID_W), .EVC_W(EVC_W), .CW(CW)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .q_valid_i   (q_valid),
    .q_bcid_i    (q_bcid),
    .q_evc_i     (q_evc),
    .q_pop_o     (q_pop),
    .rec_valid_i (rec_valid_i),
    .data_i      (data),
    .flags_i     (flags),
    .n_act_i     (n_clamp),
    .fifo_full_i (fifo_full_i),
    .fifo_wr_o   (fifo_wr_o),
    .fifo_data_o (fifo_data_o),
    .rec_taken_o (rec_taken_o)
  );

  AST_NO_WR_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_i |-> !fifo_wr_o); // R6
endmodule

// File: tb/test_event_framer.sv
module test_event_framer;
  localparam int NC = 25;
  localparam int RW = 71;

  logic          clk_i = 0;
  logic          rst_ni = 0;
  logic          trig_i = 0;
  logic [11:0]   ref_bcid_i = '0;
  logic [23:0]   ref_evcnt_i = '0;
  logic          rec_valid_i = 0;
  logic [NC*RW-1:0] rec_i;
  logic [4:0]    n_chan_i = '0;
  logic          fifo_full_i = 0;
  logic          fifo_wr_o;
  logic [31:0]   fifo_data_o;
  logic          rec_taken_o;

  logic [RW-1:0] recs [NC];
  always_comb for (int c = 0; c < NC; c++) rec_i[c*RW +: RW] = recs[c];

  event_framer i_event_framer (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  logic [31:0] exp_w [64];
  logic [31:0] got_w [64];
  int exp_len, got_len;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void build_exp(input logic [11:0] b, input logic [23:0] e, input int n_in);
    int n;
    logic [31:0] fl, p;
    n  = (n_in > NC) ? NC : n_in;
    fl = '0;
    for (int c = 0; c < n; c++)
      if (recs[c][67:64] != b[3:0] || recs[c][70:68] != e[2:0]) fl[c] = 1'b1;
    exp_w[0] = 32'hB0F0_0000;
    exp_w[1] = {20'b0, b};
    exp_w[2] = {8'b0, e};
    exp_w[3] = fl;
    exp_w[4] = 32'(n);
    for (int c = 0; c < n; c++) begin
      exp_w[5+2*c] = recs[c][63:32];
      exp_w[6+2*c] = recs[c][31:0];
    end
    p = '0;
    for (int i = 1; i < 5 + 2*n; i++) p ^= exp_w[i];
    exp_w[5+2*n] = p;
    exp_w[6+2*n] = 32'hE0F0_0000;
    exp_len = 7 + 2*n;
  endfunction

  task automatic collect(input bit stall);
    int cyc;
    bit done;
    got_len = 0;
    done = 0;
    cyc = 0;
    while (!done && cyc < 400) begin
      @(negedge clk_i);
      fifo_full_i = stall && ((cyc % 3 == 1) || (cyc % 7 == 0));
      #1;
      if (fifo_full_i && fifo_wr_o) chk(0, "R6 write while full", 32'(fifo_wr_o), 0);
      if (fifo_wr_o && got_len < 64) begin
        got_w[got_len] = fifo_data_o;
        got_len++;
      end
      if (rec_taken_o) begin
        chk(fifo_wr_o && fifo_data_o == 32'hE0F0_0000, "R8 taken with end word", fifo_data_o, 32'hE0F0_0000);
        done = 1;
      end
      cyc++;
    end
    fifo_full_i = 0;
    if (!done) chk(0, "R8 frame never completed", 0, 1);
    @(negedge clk_i); #1;
    chk(!rec_taken_o, "R8 taken single cycle", 32'(rec_taken_o), 0);
  endtask

  task automatic compare(input string tag);
    chk(got_len == exp_len, {tag, " R5 frame length"}, 32'(got_len), 32'(exp_len));
    for (int i = 0; i < exp_len && i < got_len; i++) begin
      string r;
      if (i == 3) r = "R3 flags";
      else if (i == exp_len - 2) r = "R4 parity";
      else if (i == 4) r = "R5 count";
      else r = "R2 word";
      chk(got_w[i] === exp_w[i], {tag, " ", r}, got_w[i], exp_w[i]);
    end
  endtask

  task automatic fire(input logic [11:0] b, input logic [23:0] e);
    @(negedge clk_i);
    trig_i = 1; ref_bcid_i = b; ref_evcnt_i = e;
    @(negedge clk_i);
    trig_i = 0;
  endtask

  task automatic fill(input logic [3:0] bc, input logic [2:0] l1, input int seed);
    for (int c = 0; c < NC; c++)
      recs[c] = {l1, bc, 32'(seed * 7919 + c * 104729), 32'(c * 2654435 ^ seed)};
  endtask

  task automatic one_frame(input string tag, input logic [11:0] b, input logic [23:0] e,
                           input int n, input bit stall);
    n_chan_i = 5'(n);
    rec_valid_i = 1;
    fire(b, e);
    build_exp(b, e, n);
    collect(stall);
    rec_valid_i = 0;
    compare(tag);
  endtask

  task automatic t_reset();
    #1;
    chk(!fifo_wr_o && !rec_taken_o, "R1 reset idle", {fifo_wr_o, rec_taken_o}, 0);
    repeat (3) @(negedge clk_i);
    chk(!fifo_wr_o, "R1 no write without trigger", 32'(fifo_wr_o), 0);
  endtask

  task automatic t_match();
    fill(4'h5, 3'h2, 1);
    one_frame("all-match", 12'hA35, 24'h12_345A, 25, 0);
  endtask

  task automatic t_mismatch();
    fill(4'h9, 3'h6, 2);
    recs[0][67:64]  = 4'h1; recs[0][70:68] = 3'h0;
    recs[3][67:64]  = 4'hA;
    recs[24][70:68] = 3'h5;
    one_frame("mismatch R3", 12'h7F9, 24'hABCD_E6, 25, 0);
  endtask

  task automatic t_inactive();
    fill(4'h3, 3'h1, 3);
    recs[10][67:64] = 4'hF;
    recs[2][70:68]  = 3'h7;
    one_frame("inactive R3 R5", 12'h003, 24'h000_009, 4, 0);
  endtask

  task automatic t_counts();
    fill(4'h0, 3'h0, 4);
    one_frame("zero chan R5", 12'hFF0, 24'hFFFF_F8, 0, 0);
    one_frame("clamp R5", 12'h100, 24'h000_100, 31, 0);
  endtask

  task automatic t_stall();
    fill(4'hC, 3'h4, 5);
    recs[7][67:64] = 4'h0;
    one_frame("stall R6", 12'h55C, 24'h77_7774, 25, 1);
  endtask

  task automatic t_queue();
    int extra;
    fill(4'h2, 3'h3, 6);
    n_chan_i = 5'd6;
    rec_valid_i = 0;
    fire(12'h0A2, 24'h00_0013);
    fire(12'h0B7, 24'h00_0026);
    fire(12'h0C2, 24'h00_0033);
    repeat (3) @(negedge clk_i);
    #1 chk(!fifo_wr_o, "R7 wait for records", 32'(fifo_wr_o), 0);
    rec_valid_i = 1;
    build_exp(12'h0A2, 24'h00_0013, 6);
    collect(0);
    compare("queue first R9");
    build_exp(12'h0B7, 24'h00_0026, 6);
    collect(1);
    compare("queue second R9");
    extra = 0;
    repeat (30) begin
      @(negedge clk_i); #1;
      if (fifo_wr_o) extra++;
    end
    chk(extra == 0, "R7 third trigger dropped", 32'(extra), 0);
    rec_valid_i = 0;
  endtask

  initial begin
    #2_000_000;
    chk(0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) recs[c] = '0;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    t_match();
    t_mismatch();
    t_inactive();
    t_counts();
    t_stall();
    t_queue();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule